// File: doc/BRIEF.md
# Registered Configurable Integer ALU

This block is an integer ALU meant for measuring the area and the shortest clock period of common datapath operations. It takes two 64-bit operands and a 5-bit operation code and returns one 64-bit result. The operands and the operation code are captured in registers at the input, and the result is captured in a register at the output. Every combinational path therefore starts and ends at a flip-flop, which keeps timing figures comparable from one configuration to the next.

The operations fall into five groups: arithmetic, set-on-compare, shifts, bitwise logic and byte pass-through. A build-time enable mask picks which operation codes are compiled in. Datapath units whose operations are all masked off are left out. All three shift kinds use one shared barrel shifter. The final result multiplexer covers only the enabled codes, so one netlist can be built as, for example, a shift-only or a logic-only ALU.

Top module: `mock_alu_top`

## Requirements
- R1: A synchronous, active-high reset clears the input and output registers, and `res_out` reads zero in the cycle after a reset edge.
- R2: The result for the inputs presented before clock edge N appears on `res_out` just after edge N+1. Between those two edges `res_out` still shows the earlier result. A new operation may be issued on every cycle.
- R3: Code 0 (add) returns A+B modulo 2^64 and code 1 (subtract) returns A-B modulo 2^64.
- R4: Codes 2 to 7 are the compares: 2 equal, 3 not equal, 4 signed less-than, 5 signed less-or-equal, 6 unsigned less-than, 7 unsigned less-or-equal. The signed compares treat the operands as two's complement. Bit 0 of the result is 1 when the condition holds and 0 when it does not, and bits 63:1 are zero.
- R5: Codes 8 (logical right), 9 (arithmetic right) and 10 (left) shift A by B[5:0] places. B[63:6] has no effect. Code 9 fills the vacated bits with A[63], and codes 8 and 10 fill them with zero.
- R6: Codes 11, 12 and 13 return A OR B, A AND B and A XOR B.
- R7: Codes 14 to 21 are the pass-throughs. Code 13+k places bits [8k-1:8k-8] of A, that is byte k-1, in result bits 7:0 and clears bits 63:8.
- R8: Any code from 22 to 31, and any code whose bit is clear in the build-time enable mask, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 64 | Operand A |
| b_in | input | 64 | Operand B; bits 5:0 also give the shift distance |
| op_in | input | 5 | Operation code |
| res_out | output | 64 | Registered result |

## Verification
The compare tests use an all-ones operand against one, and the most negative value against the most positive. On these pairs the signed and unsigned orderings disagree, so a design that mixes up the signed and unsigned paths, or takes the sign from the wrong bit, returns the opposite answer. The shift tests use distances 0 and 63 and set B's upper bits, which catches a fill bit of the wrong polarity, a left shift that is not mirrored correctly, or a distance decoded from too many bits. Add and subtract are checked at the wrap-around points, and every pass-through byte is checked with a pattern whose bytes all differ, which exposes an off-by-one byte choice. The pipelined test issues two operations back to back and samples the output between edges, so one register too many or too few shows up as a shifted result stream.

// File: rtl/mock_alu_pkg.sv
package mock_alu_pkg;

    localparam int OP_W     = 5;
    localparam int OP_COUNT = 22;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_EQ   = 5'd2,
        OP_NE   = 5'd3,
        OP_LT   = 5'd4,
        OP_LE   = 5'd5,
        OP_ULT  = 5'd6,
        OP_ULE  = 5'd7,
        OP_SHR  = 5'd8,
        OP_SRA  = 5'd9,
        OP_SHL  = 5'd10,
        OP_OR   = 5'd11,
        OP_AND  = 5'd12,
        OP_XOR  = 5'd13,
        OP_MUX1 = 5'd14,
        OP_MUX2 = 5'd15,
        OP_MUX3 = 5'd16,
        OP_MUX4 = 5'd17,
        OP_MUX5 = 5'd18,
        OP_MUX6 = 5'd19,
        OP_MUX7 = 5'd20,
        OP_MUX8 = 5'd21
    } op_e;

    typedef enum logic [1:0] {
        SH_RIGHT_LOGIC = 2'd0,
        SH_RIGHT_ARITH = 2'd1,
        SH_LEFT        = 2'd2
    } shift_kind_e;

    function automatic logic is_cmp(logic [OP_W-1:0] op);
        return (op >= OP_EQ) && (op <= OP_ULE);
    endfunction

    function automatic logic is_shift(logic [OP_W-1:0] op);
        return (op >= OP_SHR) && (op <= OP_SHL);
    endfunction

    function automatic logic is_passthru(logic [OP_W-1:0] op);
        return (op >= OP_MUX1) && (op <= OP_MUX8);
    endfunction

endpackage

// File: rtl/mock_alu_arith.sv
module mock_alu_arith
    import mock_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res
);

    logic         sub;
    logic [W:0]   total;
    logic [W-1:0] diff;
    logic         no_borrow;
    logic         zero;
    logic         lt_u;
    logic         lt_s;
    logic         cond;

    // one adder serves add, subtract and every compare
    always_comb begin
        sub       = (op != OP_ADD);
        total     = {1'b0, a} + {1'b0, b ^ {W{sub}}} + {{W{1'b0}}, sub};
        diff      = total[W-1:0];
        no_borrow = total[W];
        zero      = (diff == '0);
        lt_u      = ~no_borrow;
        lt_s      = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];
        cond      = 1'b0;
        case (op)
            OP_EQ:   cond = zero;
            OP_NE:   cond = ~zero;
            OP_LT:   cond = lt_s;
            OP_LE:   cond = lt_s | zero;
            OP_ULT:  cond = lt_u;
            OP_ULE:  cond = lt_u | zero;
            default: cond = 1'b0;
        endcase
        res = is_cmp(op) ? {{(W-1){1'b0}}, cond} : diff;
    end

endmodule

// File: rtl/mock_alu_shift.sv
module mock_alu_shift
    import mock_alu_pkg::*;
#(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  shift_kind_e    kind,
    output logic [W-1:0]   res
);

    logic [W-1:0] stage [SHW+1];
    logic [W-1:0] src;
    logic [W-1:0] flat;
    logic         fill;

    // left shifts reuse the right shifter by mirroring the bits on both sides
    always_comb begin
        for (int i = 0; i < W; i++) begin
            src[i] = (kind == SH_LEFT) ? a[W-1-i] : a[i];
        end
        fill = (kind == SH_RIGHT_ARITH) & a[W-1];
    end

    assign stage[0] = src;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
    end

    always_comb begin
        flat = stage[SHW];
        for (int i = 0; i < W; i++) begin
            res[i] = (kind == SH_LEFT) ? flat[W-1-i] : flat[i];
        end
    end

endmodule

// File: rtl/mock_alu_logic.sv
module mock_alu_logic
    import mock_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res
);

    always_comb begin
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/mock_alu_top.sv
module mock_alu_top
    import mock_alu_pkg::*;
#(
    parameter int          W       = 64,
    parameter logic [31:0] EN_MASK = 32'h003F_FFFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [4:0]   op_in,
    output logic [W-1:0] res_out
);

    localparam int SHW      = $clog2(W);
    localparam int MUX_N    = 8;
    localparam int MUX_IW   = $clog2(MUX_N);
    localparam bit ARITH_ON = |EN_MASK[OP_ULE:OP_ADD];
    localparam bit SHIFT_ON = |EN_MASK[OP_SHL:OP_SHR];
    localparam bit LOGIC_ON = |EN_MASK[OP_XOR:OP_OR];

    typedef struct packed {
        logic [W-1:0]    a;
        logic [W-1:0]    b;
        logic [OP_W-1:0] op;
        logic [W-1:0]    res;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] arith_res;
    logic [W-1:0] shift_res;
    logic [W-1:0] logic_res;
    logic [W-1:0] pass_res [MUX_N];
    shift_kind_e  kind;
    logic [MUX_IW-1:0] pass_idx;

    function automatic logic op_on(logic [OP_W-1:0] op);
        return (int'(op) < OP_COUNT) && EN_MASK[op];
    endfunction

    if (ARITH_ON) begin : g_arith
        mock_alu_arith #(.W(W)) arith_i (
            .a   (state_q.a),
            .b   (state_q.b),
            .op  (state_q.op),
            .res (arith_res)
        );
    end else begin : g_no_arith
        assign arith_res = '0;
    end

    always_comb begin
        case (state_q.op)
            OP_SHL:  kind = SH_LEFT;
            OP_SRA:  kind = SH_RIGHT_ARITH;
            default: kind = SH_RIGHT_LOGIC;
        endcase
    end

    if (SHIFT_ON) begin : g_shift
        mock_alu_shift #(.W(W), .SHW(SHW)) shift_i (
            .a    (state_q.a),
            .amt  (state_q.b[SHW-1:0]),
            .kind (kind),
            .res  (shift_res)
        );
    end else begin : g_no_shift
        assign shift_res = '0;
    end

    if (LOGIC_ON) begin : g_logic
        mock_alu_logic #(.W(W)) logic_i (
            .a   (state_q.a),
            .b   (state_q.b),
            .op  (state_q.op),
            .res (logic_res)
        );
    end else begin : g_no_logic
        assign logic_res = '0;
    end

    for (genvar k = 0; k < MUX_N; k++) begin : g_pass
        assign pass_res[k] = {{(W-8){1'b0}}, state_q.a[8*k+7:8*k]};
    end

    always_comb begin
        pass_idx      = MUX_IW'(state_q.op - OP_MUX1);
        state_d.a     = a_in;
        state_d.b     = b_in;
        state_d.op    = op_in;
        state_d.res   = '0;
        if (op_on(state_q.op)) begin
            if (state_q.op <= OP_ULE) begin
                state_d.res = arith_res;
            end else if (is_shift(state_q.op)) begin
                state_d.res = shift_res;
            end else if (state_q.op <= OP_XOR) begin
                state_d.res = logic_res;
            end else begin
                state_d.res = pass_res[pass_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_out = state_q.res;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (res_out == '0));

    a_r4_cmp_boolean: assert property (@(posedge clk) disable iff (rst)
        (is_cmp(state_q.op) && op_on(state_q.op)) |=> (res_out[W-1:1] == '0));

    a_r5_shift_by_zero: assert property (@(posedge clk) disable iff (rst)
        (is_shift(state_q.op) && op_on(state_q.op) && state_q.b[SHW-1:0] == '0)
        |=> (res_out == $past(state_q.a)));

    a_r7_pass_zero_ext: assert property (@(posedge clk) disable iff (rst)
        is_passthru(state_q.op) |=> (res_out[W-1:8] == '0));

    a_r8_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        !op_on(state_q.op) |=> (res_out == '0));

endmodule

// File: tb/mock_alu_tb.sv
`timescale 1ns/1ps
module mock_alu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;
    logic [4:0]  op_in = '0;
    logic [63:0] res_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mock_alu_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .b_in    (b_in),
        .op_in   (op_in),
        .res_out (res_out)
    );

    function automatic logic [63:0] model(logic [4:0] op, logic [63:0] a, logic [63:0] b);
        int sh;
        sh = int'(b[5:0]);
        case (op)
            5'd0:  return a + b;
            5'd1:  return a - b;
            5'd2:  return {63'd0, a == b};
            5'd3:  return {63'd0, a != b};
            5'd4:  return {63'd0, $signed(a) < $signed(b)};
            5'd5:  return {63'd0, $signed(a) <= $signed(b)};
            5'd6:  return {63'd0, a < b};
            5'd7:  return {63'd0, a <= b};
            5'd8:  return a >> sh;
            5'd9:  return 64'($signed(a) >>> sh);
            5'd10: return a << sh;
            5'd11: return a | b;
            5'd12: return a & b;
            5'd13: return a ^ b;
            default: begin
                if (op >= 5'd14 && op <= 5'd21)
                    return {56'd0, 8'(a >> (8 * (int'(op) - 14)))};
                return 64'd0;
            end
        endcase
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(string req, logic [4:0] op, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        op_in = op; a_in = a; b_in = b;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(req, res_out, model(op, a, b));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        op_in = 5'd0; a_in = 64'h5; b_in = 64'h7;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", res_out, 64'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_arith;
        run("R3 add", 5'd0, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111);
        run("R3 add wrap", 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        run("R3 sub", 5'd1, 64'd1000, 64'd1);
        run("R3 sub wrap", 5'd1, 64'd0, 64'd1);
    endtask

    task automatic t_compare;
        for (int op = 2; op <= 7; op++) begin
            run("R4 neg vs one", 5'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
            run("R4 equal", 5'(op), 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
            run("R4 min vs max", 5'(op), 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
            run("R4 small", 5'(op), 64'd3, 64'd9);
        end
    endtask

    task automatic t_shift;
        for (int op = 8; op <= 10; op++) begin
            run("R5 by zero", 5'(op), 64'h9234_5678_9ABC_DEF1, 64'd0);
            run("R5 by 63", 5'(op), 64'h9234_5678_9ABC_DEF1, 64'd63);
            run("R5 upper B ignored", 5'(op), 64'h8000_0000_F000_0001, 64'hFFFF_FFFF_FFFF_FFC4);
            run("R5 positive", 5'(op), 64'h4000_0000_0000_00F0, 64'd17);
        end
    endtask

    task automatic t_logic;
        for (int op = 11; op <= 13; op++) begin
            run("R6 bitwise", 5'(op), 64'hF0F0_FF00_1234_AAAA, 64'h0FF0_F0F0_4321_5555);
        end
    endtask

    task automatic t_pass;
        for (int op = 14; op <= 21; op++) begin
            run("R7 byte select", 5'(op), 64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF);
        end
    endtask

    task automatic t_undef;
        run("R8 code 22", 5'd22, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234);
        run("R8 code 31", 5'd31, 64'hDEAD_BEEF_0000_0001, 64'd7);
    endtask

    task automatic t_pipe;
        logic [63:0] prev;
        run("R2 setup", 5'd11, 64'h00AA, 64'h0F00);
        prev = res_out;
        @(negedge clk);
        op_in = 5'd0; a_in = 64'd40; b_in = 64'd2;
        @(posedge clk);
        #1;
        check("R2 old result held", res_out, prev);
        @(negedge clk);
        op_in = 5'd13; a_in = 64'hFF; b_in = 64'h0F;
        @(posedge clk);
        #1;
        check("R2 first result", res_out, 64'd42);
        @(posedge clk);
        #1;
        check("R2 second result", res_out, 64'hF0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_compare();
        t_shift();
        t_logic();
        t_pass();
        t_undef();
        t_pipe();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule